// File: doc/BRIEF.md
# Host-Mapped SPI Port with Buffer-Full Status

This block is an SPI port that a host processor reaches through three byte-wide registers: data, status and control. It can run as the bus master, dividing the system clock to make the serial clock, or as a slave that follows an external serial clock while its select input is low. Frames are 8 bits, most significant bit first. The port uses mode 0: the input line is sampled on the rising edge of the serial clock and the output line changes on the falling edge.

The host never sees the shift register. Writing the data register loads the outgoing byte. In master mode that write also starts the frame. When the eighth bit has moved, the incoming byte becomes readable through the same data register. At that point a buffer-full flag sets, a one-cycle interrupt pulse is raised and a sticky completion flag is latched. Reading the data register clears buffer-full. A data write while a frame is in progress is a collision: it is flagged and otherwise ignored. Clearing the enable bit stops the port and returns it to its idle state so that it can be reconfigured.

Top module: `spi_port`

## Requirements
- R1: After reset, the status, control and data registers all read 0, and irq_o, sck_o, sck_oe_o and sdo_o are all low.
- R2: With enable (control bit 5) and master (control bit 4) set, a data write (address 0) that is accepted starts a frame. sdo_o presents the written byte MSB first and changes only while sck_o is low. sdi_i is sampled on each rising sck_o edge. After the frame, a read of address 0 returns the received byte. sck_o idles low.
- R3: Status bit 0 (buffer full) sets when a frame completes. A read of the data register (address 0) clears it.
- R4: Completion raises irq_o for exactly one cycle and sets sticky status bit 2. A status write (address 1) with bit 2 at 0 clears bit 2. Writing 1 to bit 2 leaves it unchanged.
- R5: A data write while a frame is in progress sets status bit 1. That write does not change the outgoing frame or the received byte. A status write with bit 1 at 0 clears bit 1.
- R6: With enable set and master clear, sck_oe_o stays low. Each frame is clocked by sck_i while ss_n_i is low. On each falling sck_i edge, sdo_o moves to the next bit of the loaded byte. After 8 bits, the byte sampled from sdi_i is in the data register, and status bits 0 and 2 are set.
- R7: In slave mode, sck_i edges are ignored while ss_n_i is high. The shift position, the flags and the data register do not change.
- R8: Clearing the enable bit aborts any frame. It clears status bits 0 to 3 and the data register, and stops sck_o. Data writes while disabled start nothing. The control register keeps its value.
- R9: Control bits 1:0 select the master clock divider: 0 gives /4, 1 gives /16, 2 gives /64 and 3 gives /256. An accepted master write is followed by irq_o after exactly 8 × divider cycles.
- R10: Status bit 3 (busy) is set while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write qualifier |
| host_rd | input | 1 | Host read qualifier (side effects) |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| irq_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock drive enable (master and enabled) |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
If the bit counter or the master-active state is corrupted, the irq_o pulse comes too early or too late against the 8 × divider count, or the captured outgoing byte is rotated. Either fault shows up within one frame. A sticky flag that is not cleared, or a buffer that a colliding write overwrites, appears on the next status or data read. A select gate that leaks edges while ss_n_i is high moves the slave's shift position. The next legal frame then returns the wrong outgoing byte.

// File: rtl/spi_port_pkg.sv
// Package: shared register addresses and field positions of the SPI port.
// Assumes a byte-wide host bus with a two-bit register address.
package spi_port_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CTRL = 2'd2
    } reg_addr_e;

    // Status field positions
    localparam int ST_FULL = 0;
    localparam int ST_COL  = 1;
    localparam int ST_DONE = 2;
    localparam int ST_BUSY = 3;

    // Control field positions
    localparam int CT_EN  = 5;
    localparam int CT_MST = 4;

endpackage

// File: rtl/spi_port_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is sampled independently; RST_VAL sets the idle level per bit.
module spi_port_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage re-registers the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_port_clkgen.sv
// Master serial-clock generator. While run is high, it toggles sck every
// half-period (2 << 2*ps system cycles) and flags the rising and falling toggles.
// Assumes run drops in the same cycle as the final falling toggle, or later.
module spi_port_clkgen #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            sck,
    output logic            rise,
    output logic            fall
);

    localparam int CNT_W = 2 * (1 << PS_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             tick;

    // Terminal count of one half-period for the selected divider
    always_comb half_m1 = (CNT_W'(2) << {ps, 1'b0}) - CNT_W'(1);

    assign tick = run && (cnt == half_m1);
    assign rise = tick && !sck;
    assign fall = tick && sck;

    // Half-period counter and clock toggle; both idle low when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck); // R2

endmodule

// File: rtl/spi_port_shifter.sv
// Shift engine. Samples sdi on rise, shifts on fall (mode 0, MSB first),
// counts DW bits and then pulses done, holding the received word in rx_data.
// Assumes load arrives only when idle and that rise and fall never coincide.
module spi_port_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdi,
    output logic          sdo,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);

    localparam int CW = $clog2(DW);

    logic [DW-1:0] shreg;
    logic          samp;
    logic          half;
    logic [CW-1:0] bitcnt;
    logic          mst_act;

    assign sdo  = shreg[DW-1];
    assign busy = mst_act || half || (bitcnt != '0);

    // Shift, bit count and completion; disabling returns everything to idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shreg   <= '0;
            samp    <= 1'b0;
            half    <= 1'b0;
            bitcnt  <= '0;
            mst_act <= 1'b0;
            done    <= 1'b0;
            rx_data <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg   <= load_data;
                mst_act <= master;
            end else begin
                if (rise) begin
                    samp <= sdi;
                    half <= 1'b1;
                end
                if (fall) begin
                    shreg <= {shreg[DW-2:0], samp};
                    half  <= 1'b0;
                    if (bitcnt == CW'(DW-1)) begin
                        bitcnt  <= '0;
                        done    <= 1'b1;
                        rx_data <= {shreg[DW-2:0], samp};
                        mst_act <= 1'b0;
                    end else begin
                        bitcnt <= bitcnt + CW'(1);
                    end
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy); // R8

endmodule

// File: rtl/spi_port.sv
// SPI port top. Decodes the host registers (data, status, control), gates data
// writes into loads or collisions, selects master or synchronized slave clock
// edges for the shift engine, and keeps the sticky status flags.
// Assumes one host access per cycle; host_rdata is combinational.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int PS_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq_o,
    output logic          sck_o,
    output logic          sck_oe_o,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          sdi_i,
    output logic          sdo_o
);

    logic            en_q, mst_q;
    logic [PS_W-1:0] ps_q;
    logic            full_q, col_q, done_q;

    logic wr_data, wr_stat, wr_ctrl, rd_data;
    logic load, col_evt;
    logic busy, done_pulse, sdo_raw;
    logic [DW-1:0] rx_data;

    logic m_sck, m_rise, m_fall;
    logic sck_s, ss_s, sdi_s, sck_prev;
    logic s_rise, s_fall, slv_ok;
    logic rise_sel, fall_sel, sdi_sel;

    // Host access decode
    always_comb begin
        wr_data = host_sel && host_wr && (host_addr == ADDR_DATA);
        wr_stat = host_sel && host_wr && (host_addr == ADDR_STAT);
        wr_ctrl = host_sel && host_wr && (host_addr == ADDR_CTRL);
        rd_data = host_sel && host_rd && (host_addr == ADDR_DATA);
    end

    assign load    = wr_data && en_q && !busy;
    assign col_evt = wr_data && en_q && busy;

    // Control register: enable, master select, divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mst_q <= 1'b0;
            ps_q  <= '0;
        end else if (wr_ctrl) begin
            en_q  <= host_wdata[CT_EN];
            mst_q <= host_wdata[CT_MST];
            ps_q  <= host_wdata[PS_W-1:0];
        end
    end

    // Sticky status flags; all cleared while the port is disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) begin
            full_q <= 1'b0;
            col_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (done_pulse)   full_q <= 1'b1;
            else if (rd_data) full_q <= 1'b0;
            if (col_evt)                           col_q <= 1'b1;
            else if (wr_stat && !host_wdata[ST_COL]) col_q <= 1'b0;
            if (done_pulse)                         done_q <= 1'b1;
            else if (wr_stat && !host_wdata[ST_DONE]) done_q <= 1'b0;
        end
    end

    // Slave-side inputs brought into the system clock domain
    spi_port_sync #(
        .W       (3),
        .STAGES  (2),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdi_i, ss_n_i, sck_i}),
        .q     ({sdi_s, ss_s, sck_s})
    );

    // Previous synchronized slave clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign slv_ok = en_q && !mst_q && !ss_s;
    assign s_rise = slv_ok && sck_s && !sck_prev;
    assign s_fall = slv_ok && !sck_s && sck_prev;

    spi_port_clkgen #(
        .PS_W (PS_W)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q && mst_q && busy),
        .ps    (ps_q),
        .sck   (m_sck),
        .rise  (m_rise),
        .fall  (m_fall)
    );

    // Edge and data source selection by mode
    always_comb begin
        rise_sel = mst_q ? m_rise : s_rise;
        fall_sel = mst_q ? m_fall : s_fall;
        sdi_sel  = mst_q ? sdi_i  : sdi_s;
    end

    spi_port_shifter #(
        .DW (DW)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .master    (mst_q),
        .load      (load),
        .load_data (host_wdata),
        .rise      (rise_sel),
        .fall      (fall_sel),
        .sdi       (sdi_sel),
        .sdo       (sdo_raw),
        .busy      (busy),
        .done      (done_pulse),
        .rx_data   (rx_data)
    );

    assign irq_o    = done_pulse;
    assign sck_oe_o = en_q && mst_q;
    assign sck_o    = m_sck && sck_oe_o;
    assign sdo_o    = sdo_raw && en_q;

    // Host read multiplexer
    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            case (host_addr)
                ADDR_DATA: host_rdata = rx_data;
                ADDR_STAT: begin
                    host_rdata[ST_FULL] = full_q;
                    host_rdata[ST_COL]  = col_q;
                    host_rdata[ST_DONE] = done_q;
                    host_rdata[ST_BUSY] = busy;
                end
                ADDR_CTRL: begin
                    host_rdata[CT_EN]       = en_q;
                    host_rdata[CT_MST]      = mst_q;
                    host_rdata[PS_W-1:0]    = ps_q;
                end
                default: host_rdata = '0;
            endcase
        end
    end

    AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse && en_q |=> full_q); // R3

    AST_COL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        col_evt && !fall_sel |=> $stable(rx_data)); // R5

    AST_SS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !mst_q && ss_s && !busy |=> !busy); // R7

endmodule

// File: tb/spi_port_tb.sv
// Scoreboard bench: the driver pushes expected outgoing frames into a queue,
// and a monitor rebuilds frames from sck_o/sdo_o and compares them against it.
module spi_port_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq_o, sck_o, sck_oe_o, sdo_o;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, sdi_drv = 1'b0, sdi_i;
    logic       mst_tb = 1'b0;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_tx[$];
    logic [7:0] sl_byte = 8'h00;
    int         sl_cnt = 0;
    int         sl_base = 0;

    spi_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_o      (irq_o),
        .sck_o      (sck_o),
        .sck_oe_o   (sck_oe_o),
        .sck_i      (sck_i),
        .ss_n_i     (ss_n_i),
        .sdi_i      (sdi_i),
        .sdo_o      (sdo_o)
    );

    // Remote slave model for master mode: next bit after each falling sck_o
    function automatic logic sl_bit(input logic [7:0] b, input int c, input int base);
        int k;
        k = c - base;
        if (k >= 0 && k < 8) return b[7-k];
        return 1'b0;
    endfunction

    always @(negedge sck_o) sl_cnt <= sl_cnt + 1;
    assign sdi_i = mst_tb ? sl_bit(sl_byte, sl_cnt, sl_base) : sdi_drv;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: rebuild outgoing frames on rising sck_o and score them
    logic       prev_sck = 1'b0;
    int         mbits = 0;
    logic [7:0] mword = 8'h00;
    always @(negedge clk) begin
        if (!sck_oe_o) begin
            mbits = 0;
        end else if (sck_o && !prev_sck) begin
            mword = {mword[6:0], sdo_o};
            mbits++;
            if (mbits == 8) begin
                mbits = 0;
                if (exp_tx.size() == 0)
                    check(1'b0, "R2", "unexpected outgoing frame", int'(mword), -1);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(mword === e, "R2", "outgoing frame", int'(mword), int'(e));
                end
            end
        end
        prev_sck = sck_o;
    end

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0;
    endtask

    task automatic master_xfer(input logic [1:0] ps, input logic [7:0] tx,
                               input logic [7:0] sl);
        logic [7:0] r;
        int         cnt;
        hw(2'd2, 8'h30 | {6'd0, ps});
        mst_tb  = 1'b1;
        sl_byte = sl;
        sl_base = sl_cnt;
        exp_tx.push_back(tx);
        hw(2'd0, tx);
        cnt = 0;
        hr(2'd1, r);
        cnt += 2;
        check(r[3] === 1'b1, "R10", "busy during frame", int'(r), 8);
        while (!irq_o && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 16 * (2 << (2 * int'(ps))), "R9", "cycles to completion",
              cnt, 16 * (2 << (2 * int'(ps))));
        @(negedge clk);
        check(irq_o === 1'b0, "R4", "irq pulse width", int'(irq_o), 0);
        hr(2'd1, r);
        check(r === 8'h05, "R3", "status after frame", int'(r), 5);
        hr(2'd0, r);
        check(r === sl, "R2", "received byte", int'(r), int'(sl));
        hr(2'd1, r);
        check(r === 8'h04, "R3", "full cleared by data read", int'(r), 4);
        hw(2'd1, 8'h00);
        hr(2'd1, r);
        check(r === 8'h00, "R4", "done cleared by writing 0", int'(r), 0);
    endtask

    task automatic slave_frame(input logic [7:0] m, output logic [7:0] got);
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            sdi_drv = m[i];
            repeat (8) @(negedge clk);
            got[i] = sdo_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (12) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver
    initial begin
        logic [7:0] r;
        logic [7:0] got;
        bit         bad;
        logic [7:0] txs [4];
        logic [7:0] sls [4];
        txs = '{8'h96, 8'h01, 8'hFF, 8'h3C};
        sls = '{8'h5A, 8'h80, 8'h00, 8'hC3};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(irq_o === 1'b0 && sck_o === 1'b0 && sck_oe_o === 1'b0 && sdo_o === 1'b0,
              "R1", "pins after reset", int'({irq_o, sck_o, sck_oe_o, sdo_o}), 0);
        hr(2'd1, r); check(r === 8'h00, "R1", "status after reset", int'(r), 0);
        hr(2'd2, r); check(r === 8'h00, "R1", "control after reset", int'(r), 0);
        hr(2'd0, r); check(r === 8'h00, "R1", "data after reset", int'(r), 0);

        // R2, R9: master frames under every divider
        for (int p = 0; p < 4; p++) master_xfer(2'(p), txs[p], sls[p]);

        // R5: collision during a master frame
        hw(2'd2, 8'h31);
        sl_byte = 8'h3C; sl_base = sl_cnt;
        exp_tx.push_back(8'hA5);
        hw(2'd0, 8'hA5);
        repeat (20) @(negedge clk);
        hw(2'd0, 8'hFF);
        hr(2'd1, r); check(r === 8'h0A, "R5", "collision and busy flagged", int'(r), 10);
        while (!irq_o) @(negedge clk);
        @(negedge clk);
        hr(2'd1, r); check(r === 8'h07, "R5", "status after collided frame", int'(r), 7);
        hr(2'd0, r); check(r === 8'h3C, "R5", "received byte kept", int'(r), 60);
        hw(2'd1, 8'hFD);
        hr(2'd1, r); check(r === 8'h04, "R5", "collision cleared, done kept (R4)", int'(r), 4);
        hw(2'd1, 8'h00);

        // R8: disable aborts a frame and resets the port
        hw(2'd2, 8'h32);
        sl_byte = 8'h11; sl_base = sl_cnt;
        hw(2'd0, 8'h11);
        repeat (100) @(negedge clk);
        hw(2'd2, 8'h12);
        hr(2'd1, r); check(r === 8'h00, "R8", "status after disable", int'(r), 0);
        hr(2'd0, r); check(r === 8'h00, "R8", "data cleared by disable", int'(r), 0);
        hr(2'd2, r); check(r === 8'h12, "R8", "control kept", int'(r), 18);
        hw(2'd0, 8'h77);
        bad = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq_o || sck_o) bad = 1'b1;
        end
        check(!bad, "R8", "no clock or irq while disabled", int'(bad), 0);
        hr(2'd1, r); check(r === 8'h00, "R8", "idle after disabled write", int'(r), 0);
        master_xfer(2'd0, 8'h81, 8'h7E);

        // R6: slave frame
        mst_tb = 1'b0;
        hw(2'd2, 8'h20);
        check(sck_oe_o === 1'b0, "R6", "clock not driven in slave", int'(sck_oe_o), 0);
        hw(2'd0, 8'hC3);
        slave_frame(8'h69, got);
        check(got === 8'hC3, "R6", "slave outgoing byte", int'(got), 195);
        hr(2'd1, r); check(r === 8'h05, "R6", "slave status", int'(r), 5);
        hr(2'd0, r); check(r === 8'h69, "R6", "slave received byte", int'(r), 105);
        hw(2'd1, 8'h00);

        // R7: clock edges with select high are ignored
        ss_n_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sdi_drv = i[0];
            repeat (8) @(negedge clk);
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (12) @(negedge clk);
        hr(2'd1, r); check(r === 8'h00, "R7", "status after deselected edges", int'(r), 0);
        hr(2'd0, r); check(r === 8'h69, "R7", "data kept", int'(r), 105);
        slave_frame(8'h2D, got);
        check(got === 8'h69, "R7", "shift position unchanged", int'(got), 105);
        hr(2'd0, r); check(r === 8'h2D, "R6", "second slave byte", int'(r), 45);

        check(exp_tx.size() == 0, "R2", "all expected frames seen", exp_tx.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule